// File: doc/BRIEF.md
# Four-Bit Inverting Bus Transceiver with Address Match

This block sits between a shared, active-low, open-drain system bus and the active-high data lines of a peripheral. It is built as enables and data paths for a synchronous design. Each bus line is modelled as a drive-low enable, and the level read back from the bus comes in on a separate input. The device side is a tri-state port: a data vector plus one output enable. Data crosses the block inverted at the pins, so the logical value stays the same in both directions. Two control inputs pick receive (bus to device), transmit (device to bus) or disabled.

Each direction change passes through a turnaround guard. The drivers of the old direction drop in the same cycle. The drivers of the new direction turn on only after a programmable number of clock cycles, so the two sides never drive at the same time. Three vector jumpers pull the upper three bus lines regardless of the control state, which places a constant on the bus. A three-bit comparator checks bus bits 3 to 1 against per-bit jumper codes, qualified by an active-low enable, and produces an address-match flag.

Top module: `bus_xcvr4`

## Requirements
- R1: With both controls low, the block is disabled. `dev_oe_o` is 0, `bus_drv_lo_o[0]` is 0, and `bus_drv_lo_o[3:1]` follows only `vec_jmp_i`. Values on `dev_in_i` have no effect on the bus enables.
- R2: In settled receive, `dev_oe_o` is 1 and `dev_out_o[i]` is the inverse of `bus_in_ni[i]` for every bit. `bus_drv_lo_o[0]` is 0.
- R3: In settled transmit (`tx_en_i`=1, `rx_en_i`=0), `dev_oe_o` is 0 and `bus_drv_lo_o[i]` is 1 when `dev_in_i[i]` is 1 (line pulled low means logic 1), OR-ed with the vector jumper on bits 3:1.
- R4: `vec_jmp_i[k]` = 1 sets `bus_drv_lo_o[k+1]` to 1 in every state, including reset and the turnaround window. Bus bit 0 has no vector input.
- R5: When both controls are high, the block behaves as in receive.
- R6: Address jumper pair `adr_jmp_i[2k+1:2k]` governs bus bit k+1. Code 00 matches a logical 1 (`bus_in_ni` low). Code 01 matches a logical 0 (`bus_in_ni` high). Codes 10 and 11 leave the bit out of the comparison. Bus bit 0 is never compared. With `match_en_ni` low, `match_rel_o` is 1 exactly when every compared bit matches.
- R7: With `match_en_ni` high, `match_rel_o` is 0 whatever the bus and jumpers hold.
- R8: When the decoded request changes, the drivers of the previous direction go off in the same cycle. The drivers of the new direction stay off through the first TURN_CYC rising edges after the change and come on at edge TURN_CYC+1.
- R9: The device-side output enable and the bus-side data driver of bit 0 are never active together.
- R10: While `rst_ni` is low, `dev_oe_o` and `bus_drv_lo_o[0]` are 0. A request present when reset is released goes through the full turnaround wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive control |
| tx_en_i | input | 1 | Transmit control |
| bus_in_ni | input | 4 | Bus levels read back, low = logic 1 |
| bus_drv_lo_o | output | 4 | Per-line enable that pulls the bus low |
| dev_in_i | input | 4 | Device-side data read from the pins |
| dev_out_o | output | 4 | Device-side data to drive, active high |
| dev_oe_o | output | 1 | Device-side tri-state enable |
| vec_jmp_i | input | 3 | Vector jumpers for bus bits 3:1 |
| adr_jmp_i | input | 6 | Two-bit address jumper code per bus bit 3:1 |
| match_en_ni | input | 1 | Match enable, active low |
| match_rel_o | output | 1 | 1 = match line released (address matched) |

## Verification
Receive is driven with all-zero, all-one and mixed bus words so that a missing inversion or a crossed bit shows up. Transmit is driven with complementary device words, with and without vector jumpers, which separates data drive from vector drive and shows that bit 0 carries no vector. Each direction change is sampled edge by edge through the guard window, which exposes an off-by-one count or a late release of the old drivers. The comparator is given exact matches, a single-bit miss, a change on bit 0 alone, ignored bits and a forced-off enable, so that each of the three jumper codes is told apart.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef enum logic [1:0] {
    XM_OFF = 2'd0,
    XM_TX  = 2'd1,
    XM_RX  = 2'd2
  } xmode_e;

  localparam logic [1:0] AJ_ONE  = 2'b00;
  localparam logic [1:0] AJ_ZERO = 2'b01;
endpackage

// File: rtl/xcvr_dir_ctl.sv
module xcvr_dir_ctl
  import bus_xcvr_pkg::*;
#(
  parameter int TURN_CYC = 4,
  localparam int CW = $clog2(TURN_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic tx_en_i,
  output logic tx_on_o,
  output logic rx_on_o
);
  xmode_e req, req_q, gnt_q;
  logic [CW-1:0] cnt_q;

  // receive wins when both controls are set
  always_comb begin
    if (rx_en_i)      req = XM_RX;
    else if (tx_en_i) req = XM_TX;
    else              req = XM_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= XM_OFF;
      gnt_q <= XM_OFF;
      cnt_q <= '0;
    end else if (req != req_q) begin
      req_q <= req;
      gnt_q <= XM_OFF;
      cnt_q <= CW'(TURN_CYC);
    end else if (gnt_q != req_q) begin
      if (cnt_q > CW'(1)) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        cnt_q <= '0;
        gnt_q <= req_q;
      end
    end
  end

  // a stale grant is masked by the live request: old drivers drop at once
  assign tx_on_o = (gnt_q == XM_TX) && (req == XM_TX);
  assign rx_on_o = (gnt_q == XM_RX) && (req == XM_RX);
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath #(
  parameter int DW = 4,
  parameter int VW = 3,
  localparam int VLSB = DW - VW
) (
  input  logic          tx_on_i,
  input  logic          rx_on_i,
  input  logic [DW-1:0] bus_in_ni,
  input  logic [DW-1:0] dev_in_i,
  input  logic [VW-1:0] vec_jmp_i,
  output logic [DW-1:0] bus_drv_lo_o,
  output logic [DW-1:0] dev_out_o,
  output logic          dev_oe_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic vec_hit;
    if (i >= VLSB) begin : g_vec
      assign vec_hit = vec_jmp_i[i-VLSB];
    end else begin : g_novec
      assign vec_hit = 1'b0;
    end
    assign bus_drv_lo_o[i] = (tx_on_i & dev_in_i[i]) | vec_hit;
    assign dev_out_o[i]    = rx_on_i & ~bus_in_ni[i];
  end

  assign dev_oe_o = rx_on_i;
endmodule

// File: rtl/xcvr_addr_cmp.sv
module xcvr_addr_cmp
  import bus_xcvr_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic [AW-1:0]   bus_sl_ni,
  input  logic [2*AW-1:0] adr_jmp_i,
  input  logic            match_en_ni,
  output logic            match_rel_o
);
  logic [AW-1:0] bit_ok;

  for (genvar k = 0; k < AW; k++) begin : g_cmp
    logic       lv;
    logic [1:0] code;
    assign lv        = ~bus_sl_ni[k];
    assign code      = adr_jmp_i[2*k+1 -: 2];
    assign bit_ok[k] = code[1] | ((code == AJ_ZERO) ? ~lv : (code == AJ_ONE) & lv);
  end

  assign match_rel_o = ~match_en_ni & (&bit_ok);
endmodule

// File: rtl/bus_xcvr4.sv
module bus_xcvr4 #(
  parameter int DW       = 4,
  parameter int VW       = 3,
  parameter int AW       = 3,
  parameter int TURN_CYC = 4,
  localparam int ALSB    = DW - AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          tx_en_i,
  input  logic [DW-1:0] bus_in_ni,
  output logic [DW-1:0] bus_drv_lo_o,
  input  logic [DW-1:0] dev_in_i,
  output logic [DW-1:0] dev_out_o,
  output logic          dev_oe_o,
  input  logic [VW-1:0] vec_jmp_i,
  input  logic [2*AW-1:0] adr_jmp_i,
  input  logic          match_en_ni,
  output logic          match_rel_o
);
  logic tx_on, rx_on;

  xcvr_dir_ctl #(.TURN_CYC(TURN_CYC)) u_dir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_en_i (rx_en_i),
    .tx_en_i (tx_en_i),
    .tx_on_o (tx_on),
    .rx_on_o (rx_on)
  );

  xcvr_datapath #(.DW(DW), .VW(VW)) u_dp (
    .tx_on_i      (tx_on),
    .rx_on_i      (rx_on),
    .bus_in_ni    (bus_in_ni),
    .dev_in_i     (dev_in_i),
    .vec_jmp_i    (vec_jmp_i),
    .bus_drv_lo_o (bus_drv_lo_o),
    .dev_out_o    (dev_out_o),
    .dev_oe_o     (dev_oe_o)
  );

  xcvr_addr_cmp #(.AW(AW)) u_cmp (
    .bus_sl_ni   (bus_in_ni[DW-1:ALSB]),
    .adr_jmp_i   (adr_jmp_i),
    .match_en_ni (match_en_ni),
    .match_rel_o (match_rel_o)
  );
endmodule

// File: rtl/bus_xcvr4_chk.sv
module bus_xcvr4_chk #(
  parameter int DW = 4,
  parameter int VW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          tx_en_i,
  input logic [DW-1:0] bus_in_ni,
  input logic [DW-1:0] bus_drv_lo_o,
  input logic [DW-1:0] dev_out_o,
  input logic          dev_oe_o,
  input logic [VW-1:0] vec_jmp_i,
  input logic          match_en_ni,
  input logic          match_rel_o
);
  // R7
  match_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_en_ni |-> !match_rel_o);

  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_oe_o |-> !bus_drv_lo_o[0]);

  // R4
  vec_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drv_lo_o[DW-1:DW-VW] & vec_jmp_i) == vec_jmp_i);

  // R8
  tx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i || !tx_en_i) |-> !bus_drv_lo_o[0]);

  // R8
  rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |-> !dev_oe_o);

  // R8
  rx_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_i) |=> !dev_oe_o);

  // R2
  rx_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_oe_o |-> (dev_out_o == ~bus_in_ni));
endmodule

bind bus_xcvr4 bus_xcvr4_chk #(.DW(DW), .VW(VW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .tx_en_i      (tx_en_i),
  .bus_in_ni    (bus_in_ni),
  .bus_drv_lo_o (bus_drv_lo_o),
  .dev_out_o    (dev_out_o),
  .dev_oe_o     (dev_oe_o),
  .vec_jmp_i    (vec_jmp_i),
  .match_en_ni  (match_en_ni),
  .match_rel_o  (match_rel_o)
);

// File: tb/tb_bus_xcvr4.sv
`timescale 1ns/1ps
module tb_bus_xcvr4;
  localparam int TC = 4;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       rx_en, tx_en;
  logic [3:0] bus_in_n, drv_lo, dev_in, dev_out;
  logic       dev_oe;
  logic [2:0] vec;
  logic [5:0] adr;
  logic       men_n, match;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [3:0] drv;
    logic       oe;
    logic [3:0] dout;
    logic       m;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  bus_xcvr4 #(.TURN_CYC(TC)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rx_en_i      (rx_en),
    .tx_en_i      (tx_en),
    .bus_in_ni    (bus_in_n),
    .bus_drv_lo_o (drv_lo),
    .dev_in_i     (dev_in),
    .dev_out_o    (dev_out),
    .dev_oe_o     (dev_oe),
    .vec_jmp_i    (vec),
    .adr_jmp_i    (adr),
    .match_en_ni  (men_n),
    .match_rel_o  (match)
  );

  task automatic compare(input exp_t e);
    bit ok;
    total++;
    ok = (drv_lo === e.drv) && (dev_oe === e.oe) && (match === e.m) &&
         (!e.oe || dev_out === e.dout);
    if (!ok) begin
      bad++;
      $display("FAIL %s: drv=%b oe=%b dout=%b match=%b exp drv=%b oe=%b dout=%b match=%b",
               e.tag, drv_lo, dev_oe, dev_out, match, e.drv, e.oe, e.dout, e.m);
    end
  endtask

  // monitor: compares after each rising edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  task automatic step(input logic [3:0] d, input logic oe, input logic [3:0] o,
                      input logic m, input string tag);
    exp_t e;
    e.drv = d; e.oe = oe; e.dout = o; e.m = m; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_now(input logic [3:0] d, input logic oe, input string tag);
    exp_t e;
    #1;
    e.drv = d; e.oe = oe; e.dout = 4'h0; e.m = match; e.tag = tag;
    compare(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, exp done=1 got 0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; rx_en = 1'b0; tx_en = 1'b0;
    bus_in_n = 4'hF; dev_in = 4'h0; vec = 3'b101; adr = 6'h3F; men_n = 1'b0;
    idle(2);
    // R10 reset state, R4 vector active in reset
    step(4'b1010, 1'b0, 4'h0, 1'b1, "R10 reset");

    rst_ni = 1'b1; rx_en = 1'b1; vec = 3'b000; bus_in_n = 4'b0110;
    for (int k = 0; k < TC; k++) step(4'b0000, 1'b0, 4'h0, 1'b1, "R10 R8 guard after reset");
    step(4'b0000, 1'b1, 4'b1001, 1'b1, "R2 rx mixed");
    bus_in_n = 4'b0000;
    step(4'b0000, 1'b1, 4'b1111, 1'b1, "R2 rx ones");
    bus_in_n = 4'b1111; vec = 3'b110;
    step(4'b1100, 1'b1, 4'b0000, 1'b1, "R2 R4 rx zeros with vector");

    // to transmit
    vec = 3'b000; rx_en = 1'b0; tx_en = 1'b1; dev_in = 4'b0011;
    check_now(4'b0000, 1'b0, "R8 rx released at once");
    for (int k = 0; k < TC; k++) step(4'b0000, 1'b0, 4'h0, 1'b1, "R8 tx guard");
    step(4'b0011, 1'b0, 4'h0, 1'b1, "R3 tx low nibble");
    dev_in = 4'b1100; vec = 3'b010;
    step(4'b1100, 1'b0, 4'h0, 1'b1, "R3 tx high nibble");
    dev_in = 4'b0000; vec = 3'b001;
    step(4'b0010, 1'b0, 4'h0, 1'b1, "R4 vector in tx");
    dev_in = 4'b1001; vec = 3'b000;
    step(4'b1001, 1'b0, 4'h0, 1'b1, "R3 tx bit0");

    // both controls set
    rx_en = 1'b1; bus_in_n = 4'b1010;
    check_now(4'b0000, 1'b0, "R8 tx released at once");
    idle(TC);
    step(4'b0000, 1'b1, 4'b0101, 1'b1, "R5 both means receive");

    // disabled
    rx_en = 1'b0; tx_en = 1'b0; vec = 3'b111;
    check_now(4'b1110, 1'b0, "R1 disabled at once");
    idle(TC + 1);
    step(4'b1110, 1'b0, 4'h0, 1'b1, "R1 disabled settled");
    dev_in = 4'b1111;
    step(4'b1110, 1'b0, 4'h0, 1'b1, "R1 device data ignored");

    // address compare: bit3 one, bit2 zero, bit1 one
    vec = 3'b000; adr = 6'b000100; bus_in_n = 4'b0101;
    step(4'b0000, 1'b0, 4'h0, 1'b1, "R6 exact match");
    bus_in_n = 4'b0100;
    step(4'b0000, 1'b0, 4'h0, 1'b1, "R6 bit0 not compared");
    bus_in_n = 4'b0111;
    step(4'b0000, 1'b0, 4'h0, 1'b0, "R6 bit1 miss");
    bus_in_n = 4'b0001;
    step(4'b0000, 1'b0, 4'h0, 1'b0, "R6 bit2 miss");
    adr = 6'b001000; bus_in_n = 4'b0000;
    step(4'b0000, 1'b0, 4'h0, 1'b1, "R6 code 10 ignores");
    adr = 6'b001100;
    step(4'b0000, 1'b0, 4'h0, 1'b1, "R6 code 11 ignores");
    men_n = 1'b1;
    step(4'b0000, 1'b0, 4'h0, 1'b0, "R7 enable high forces low");
    men_n = 1'b0; adr = 6'b010101; bus_in_n = 4'b1110;
    step(4'b0000, 1'b0, 4'h0, 1'b1, "R6 all match zero");

    @(posedge clk);
    #2;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule